// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel flash device. A program or erase command has already been issued. The poller then reads the device's status word over and over until it can tell whether the embedded operation finished well, finished badly, or ran past a host-chosen read budget. Each read goes out through a level request and comes back with a one-cycle acknowledge that carries the data word. At the end the block raises a one-cycle done pulse. It also gives a pass flag and a timeout flag, and both flags hold their values until the next start.

The block supports two ways of detecting completion, chosen per run by a mode input. In complement mode, bit 7 of the status word is compared with bit 7 of the expected data: while the device is busy it returns the inverse of that bit. In toggle mode, bit 6 of two consecutive reads is compared: while the device is busy that bit flips on every read. In both modes, bit 5 is the device's own time-limit flag. When bit 5 is set, the poller makes the extra confirming reads, so that a read taken just as the status changed is not mistaken for a failure. Once completion is detected, one last read compares the whole word with the expected value; an erase expects 0xFF.

States: `ST_IDLE`, `ST_PRIME_RD` (first read in toggle mode), `ST_POLL_RD` (main loop), `ST_RECHK_A` / `ST_RECHK_B` (confirming reads after bit 5), `ST_VERIFY_RD` (full-word check), `ST_FINISH` (done pulse).

Transitions:
- idle→prime (start in toggle mode) and idle→poll (start in complement mode).
- prime→poll, or prime→finish when the limit is reached.
- poll→verify on a hit, poll→recheck A when bit 5 is set, poll→finish on timeout, and poll→poll otherwise.
- recheck A→recheck B in toggle mode.
- recheck A→verify or recheck A→finish in complement mode.
- recheck B→verify or recheck B→finish.
- verify→finish, then finish→idle.

Top module: `flash_status_poller`

## Requirements
- R1: A start pulse seen in `ST_IDLE` does the following:
  - it captures the mode, the expected word and the read limit;
  - it clears pass and timeout;
  - busy goes high in the next cycle.
  A start seen while busy has no effect on the run, its reads or its result.
- R2: The read request stays high until the cycle in which the acknowledge arrives. The data word is sampled in that cycle. No request is made while idle, and no read follows the final one of a run.
- R3: In complement mode (mode = 0), a read whose bit 7 equals bit 7 of the expected word means completion.
- R4: In toggle mode (mode = 1), the first read only primes the comparison. After that, a read whose bit 6 equals bit 6 of the previous read means completion.
- R5: In complement mode, take a read that is not a completion but has bit 5 set. The poller makes exactly one more read. If its bit 7 matches the expected bit 7, that is completion; otherwise the run fails with pass = 0 and timeout = 0.
- R6: In toggle mode, take a read that is not a completion but has bit 5 set. The poller makes exactly two more reads. If their bit 6 values are equal, that is completion; otherwise the run fails with pass = 0 and timeout = 0.
- R7: Completion is followed by one verify read. Pass is 1 exactly when that whole word equals the expected word (0xFF for an erase).
- R8: The first read and the main-loop reads are counted. If that count reaches the read limit without a completion and without bit 5 set, the run ends with timeout = 1 and pass = 0, and no further read is made. A limit of 0 behaves as 1.
- R9: Done is high for exactly one cycle, in the cycle after the final acknowledge. Pass and timeout keep their values from then until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| mode | input | 1 | 0 = complement on bit 7, 1 = toggle on bit 6 |
| expect_word | input | DW | Data the operation should leave behind |
| max_polls | input | CW | Read limit for first read plus main-loop reads |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_ack | input | 1 | One-cycle read acknowledge |
| rd_data | input | DW | Status word, valid with rd_ack |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run succeeded |
| tmo_err | output | 1 | Run hit the read limit |

## Verification
The hardest paths to reach are the confirming reads after bit 5: a word that is still busy with bit 5 set, followed by a confirming read that either agrees or disagrees. A random device would almost never produce that combination. The stimulus therefore comes from a scripted responder. It plays back a per-run sequence of status words built in a structured way: a busy phase of chosen length with bit 6 alternating and bit 5 set now and then, followed by settled or corrupted data. Directed scripts add the exact pass and fail cases after bit 5 in both modes, as well as a zero limit and a start pulse issued mid-run. The acknowledge delays vary at random, so the request-hold behaviour is exercised too.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int unsigned POLL_BIT   = 7;
    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned LIMIT_BIT  = 5;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PRIME_RD  = 3'd1,
        ST_POLL_RD   = 3'd2,
        ST_RECHK_A   = 3'd3,
        ST_RECHK_B   = 3'd4,
        ST_VERIFY_RD = 3'd5,
        ST_FINISH    = 3'd6
    } fps_state_e;

    typedef enum logic {
        MODE_COMPL  = 1'b0,
        MODE_TOGGLE = 1'b1
    } fps_mode_e;

endpackage

// File: rtl/fps_status_eval.sv
module fps_status_eval
    import fps_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          mode_tgl,
    input  logic [DW-1:0] cur_word,
    input  logic [DW-1:0] prev_word,
    input  logic [DW-1:0] exp_word,
    output logic          hit,
    output logic          limit_flag,
    output logic          word_match
);

    always_comb begin
        if (mode_tgl) begin
            hit = (cur_word[TOGGLE_BIT] == prev_word[TOGGLE_BIT]);
        end else begin
            hit = (cur_word[POLL_BIT] == exp_word[POLL_BIT]);
        end
        limit_flag = cur_word[LIMIT_BIT];
        word_match = (cur_word == exp_word);
    end

endmodule

// File: rtl/fps_poll_counter.sv
module fps_poll_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          reach
);

    localparam int unsigned XW = CW + 1;

    logic [CW-1:0] cnt_q;
    logic [XW-1:0] cnt_next;
    logic [XW-1:0] eff_limit;

    always_comb begin
        cnt_next  = XW'(cnt_q) + XW'(1);
        eff_limit = (limit == '0) ? XW'(1) : XW'(limit);
        reach     = (cnt_next >= eff_limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (inc && !reach) begin
            cnt_q <= cnt_next[CW-1:0];
        end
    end

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fps_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic [DW-1:0] expect_word,
    input  logic [CW-1:0] max_polls,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic          tmo_err
);

    fps_state_e    state_q, state_n;
    fps_mode_e     mode_q;
    logic [DW-1:0] exp_q;
    logic [CW-1:0] lim_q;
    logic [DW-1:0] prev_q;
    logic          pass_q, tmo_q;

    logic hit, limit_flag, word_match, reach;
    logic launch, cnt_inc, is_tgl;

    assign launch  = (state_q == ST_IDLE) && start;
    assign cnt_inc = rd_ack && ((state_q == ST_PRIME_RD) || (state_q == ST_POLL_RD));
    assign is_tgl  = (mode_q == MODE_TOGGLE);

    fps_status_eval #(.DW(DW)) u_eval (
        .mode_tgl   (is_tgl),
        .cur_word   (rd_data),
        .prev_word  (prev_q),
        .exp_word   (exp_q),
        .hit        (hit),
        .limit_flag (limit_flag),
        .word_match (word_match)
    );

    fps_poll_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .inc   (cnt_inc),
        .limit (lim_q),
        .reach (reach)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_n = mode ? ST_PRIME_RD : ST_POLL_RD;
                end
            end
            ST_PRIME_RD: begin
                if (rd_ack) begin
                    state_n = reach ? ST_FINISH : ST_POLL_RD;
                end
            end
            ST_POLL_RD: begin
                if (rd_ack) begin
                    if (hit) begin
                        state_n = ST_VERIFY_RD;
                    end else if (limit_flag) begin
                        state_n = ST_RECHK_A;
                    end else if (reach) begin
                        state_n = ST_FINISH;
                    end
                end
            end
            ST_RECHK_A: begin
                if (rd_ack) begin
                    if (is_tgl) begin
                        state_n = ST_RECHK_B;
                    end else begin
                        state_n = hit ? ST_VERIFY_RD : ST_FINISH;
                    end
                end
            end
            ST_RECHK_B: begin
                if (rd_ack) begin
                    state_n = hit ? ST_VERIFY_RD : ST_FINISH;
                end
            end
            ST_VERIFY_RD: begin
                if (rd_ack) begin
                    state_n = ST_FINISH;
                end
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // run context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_COMPL;
            exp_q  <= '0;
            lim_q  <= '0;
            prev_q <= '0;
            pass_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (launch) begin
            mode_q <= fps_mode_e'(mode);
            exp_q  <= expect_word;
            lim_q  <= max_polls;
            prev_q <= '0;
            pass_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (rd_ack) begin
            prev_q <= rd_data;
            if (state_q == ST_PRIME_RD && reach) begin
                tmo_q <= 1'b1;
            end
            if (state_q == ST_POLL_RD && !hit && !limit_flag && reach) begin
                tmo_q <= 1'b1;
            end
            if (state_q == ST_VERIFY_RD) begin
                pass_q <= word_match;
            end
        end
    end

    // outputs
    always_comb begin
        rd_req  = (state_q == ST_PRIME_RD) || (state_q == ST_POLL_RD) ||
                  (state_q == ST_RECHK_A)  || (state_q == ST_RECHK_B) ||
                  (state_q == ST_VERIFY_RD);
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        pass    = pass_q;
        tmo_err = tmo_q;
    end

endmodule

// File: rtl/fps_poller_chk.sv
module fps_poller_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic pass,
    input logic tmo_err,
    input logic rd_req,
    input logic rd_ack
);

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    idle_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    // R8
    tmo_nopass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> !pass);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pass) && $stable(tmo_err)));

endmodule

bind flash_status_poller fps_poller_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .pass    (pass),
    .tmo_err (tmo_err),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack)
);

// File: tb/flash_status_poller_tb.sv
module flash_status_poller_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SCR_LEN    = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [7:0] expect_word = 8'h00;
    logic [15:0] max_polls = 16'd0;
    logic       rd_req;
    logic       rd_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       busy, done, pass, tmo_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [7:0] script [SCR_LEN];
    int ridx = 0;
    int wait_cnt = 0;
    int dly_max = 0;

    flash_status_poller #(.DW(8), .CW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .expect_word(expect_word), .max_polls(max_polls),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .pass(pass), .tmo_err(tmo_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // scripted status-word responder
    always @(negedge clk) begin
        cycles++;
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            if (wait_cnt == 0) begin
                rd_ack  = 1'b1;
                rd_data = (ridx < SCR_LEN) ? script[ridx] : 8'hFF;
                ridx++;
                wait_cnt = int'($urandom_range(0, dly_max));
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference outcome computed from the requirement text
    function automatic void model(input bit m, input logic [7:0] e, input int lim_in,
                                  output bit p, output bit t, output int reads);
        int i = 0;
        int cnt = 0;
        int lim = (lim_in == 0) ? 1 : lim_in;
        logic [7:0] prev = 8'h00;
        logic [7:0] d;
        bit verify = 1'b0;
        bit over = 1'b0;
        p = 1'b0;
        t = 1'b0;
        if (m) begin
            prev = script[i]; i++; cnt++;
            if (cnt >= lim) begin t = 1'b1; over = 1'b1; end
        end
        while (!over) begin
            d = script[i]; i++; cnt++;
            if (m ? (d[6] == prev[6]) : (d[7] == e[7])) begin
                verify = 1'b1; over = 1'b1;
            end else if (d[5]) begin
                if (m) begin
                    logic [7:0] a, b;
                    a = script[i]; i++;
                    b = script[i]; i++;
                    verify = (a[6] == b[6]);
                end else begin
                    d = script[i]; i++;
                    verify = (d[7] == e[7]);
                end
                over = 1'b1;
            end else if (cnt >= lim) begin
                t = 1'b1; over = 1'b1;
            end else begin
                prev = d;
            end
        end
        if (verify) begin
            p = (script[i] == e);
            i++;
        end
        reads = i;
    endfunction

    task automatic run_case(input string req, input bit m, input logic [7:0] e,
                            input int lim, input int dmax, input bit mid,
                            input bit ep, input bit et, input int er);
        int guard = 0;
        int r_at_done;
        ridx = 0;
        wait_cnt = 0;
        dly_max = dmax;
        @(negedge clk);
        mode = m; expect_word = e; max_polls = 16'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        if (mid) begin
            start = 1'b1; mode = ~m; expect_word = ~e; max_polls = 16'd1;
            @(negedge clk);
            start = 1'b0; mode = m;
        end
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk({req, " done seen"}, int'(done), 1);
        chk({req, " pass"}, int'(pass), int'(ep));
        chk({req, " R8 timeout flag"}, int'(tmo_err), int'(et));
        chk({req, " R2 read count"}, ridx, er);
        r_at_done = ridx;
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);
        chk("R9 pass held", int'(pass), int'(ep));
        repeat (3) @(negedge clk);
        chk("R2 no read after finish", ridx, r_at_done);
        chk("R9 timeout held", int'(tmo_err), int'(et));
    endtask

    task automatic load(input logic [7:0] w [8]);
        for (int i = 0; i < SCR_LEN; i++) script[i] = (i < 8) ? w[i] : 8'hFF;
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] w [8];
        void'($urandom(32'd20250));
        for (int i = 0; i < SCR_LEN; i++) script[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", int'(busy), 0);
        chk("R9 reset done", int'(done), 0);
        chk("R2 reset req", int'(rd_req), 0);
        chk("R7 reset pass", int'(pass), 0);
        chk("R8 reset timeout", int'(tmo_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: two busy words (bit7=1 vs expected 0), then hit, verify
        w = '{8'h80, 8'h80, 8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00};
        load(w); run_case("R3 complement pass", 1'b0, 8'h5A, 10, 2, 1'b0, 1'b1, 1'b0, 4);
        // R5: bit5 set, recheck matches
        w = '{8'h80, 8'hA0, 8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00};
        load(w); run_case("R5 recheck pass", 1'b0, 8'h5A, 10, 1, 1'b0, 1'b1, 1'b0, 4);
        // R5: bit5 set, recheck still busy -> fail
        w = '{8'hA0, 8'hA0, 8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00};
        load(w); run_case("R5 recheck fail", 1'b0, 8'h5A, 10, 0, 1'b0, 1'b0, 1'b0, 2);
        // R4: toggle erase, bit6 0,1,0,1,1 then verify FF
        w = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'hFF, 8'h00, 8'h00};
        load(w); run_case("R4 toggle erase pass", 1'b1, 8'hFF, 10, 3, 1'b0, 1'b1, 1'b0, 6);
        // R6: bit5 while toggling, two equal rechecks
        w = '{8'h00, 8'h60, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00};
        load(w); run_case("R6 recheck pass", 1'b1, 8'hFF, 10, 1, 1'b0, 1'b1, 1'b0, 5);
        // R6: rechecks still toggling -> fail
        w = '{8'h00, 8'h60, 8'h20, 8'h60, 8'hFF, 8'h00, 8'h00, 8'h00};
        load(w); run_case("R6 recheck fail", 1'b1, 8'hFF, 10, 0, 1'b0, 1'b0, 1'b0, 4);
        // R7: completion but verify word differs
        w = '{8'h7F, 8'hFE, 8'hFE, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        load(w); run_case("R7 verify mismatch", 1'b0, 8'hFF, 10, 1, 1'b0, 1'b0, 1'b0, 3);
        // R8: limit 3, never completes
        w = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        load(w); run_case("R8 limit reached", 1'b0, 8'h80, 3, 2, 1'b0, 1'b0, 1'b1, 3);
        // R8: limit 0 acts as 1 (toggle prime only)
        load(w); run_case("R8 zero limit", 1'b1, 8'hFF, 0, 0, 1'b0, 1'b0, 1'b1, 1);
        // R1: start while busy ignored
        w = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 8'h00, 8'h00};
        load(w); run_case("R1 start while busy", 1'b0, 8'h80, 10, 2, 1'b1, 1'b1, 1'b0, 6);

        // constrained random runs checked against the model
        for (int n = 0; n < 120; n++) begin
            bit m, ep, et;
            int er, lim, len, dm;
            logic [7:0] e, b;
            m   = 1'($urandom_range(0, 1));
            e   = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
            len = int'($urandom_range(0, 10));
            lim = int'($urandom_range(0, 12));
            dm  = int'($urandom_range(0, 3));
            for (int i = 0; i < SCR_LEN; i++) begin
                if (i < len) begin
                    b = 8'($urandom);
                    b[7] = ~e[7];
                    b[6] = 1'(i);
                    b[5] = ($urandom_range(0, 5) == 0);
                end else begin
                    b = ($urandom_range(0, 4) == 0) ? 8'($urandom) : e;
                end
                script[i] = b;
            end
            model(m, e, lim, ep, et, er);
            run_case(m ? "R4 R6 R7 random toggle" : "R3 R5 R7 random complement",
                     m, e, lim, dm, (er >= 3 && n[2]), ep, et, er);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule